// File: doc/BRIEF.md
# Saturating Crossed Halfword Add/Subtract Unit

This execution unit handles one packed-halfword operation. It receives a 32-bit instruction word, a select that says which of two encodings the word uses, a condition-passed flag from the issue stage, and two 32-bit source operands. It checks the word against the selected encoding and pulls out three register indices.

It then computes two 16-bit lanes from crossed halfwords. The low half of operand A is added to the high half of operand B. The high half of operand B's partner, operand B's low half, is subtracted from the high half of operand A. Each lane is clamped to the signed 16-bit range on its own.

One clock after an accepted input, the unit presents the packed result, the destination index, a write enable, a flag for unpredictable register use and a flag for an unrecognised word, together with a valid pulse. The register file, condition evaluation and fetch sit outside this block.

Top module: `hsx_unit`

## Requirements
- R1: Result bits [15:0] equal the signed sum of operand A bits [15:0] and operand B bits [31:16], saturated to 16 bits.
- R2: Result bits [31:16] equal operand A bits [31:16] minus operand B bits [15:0], taken as signed values and saturated to 16 bits.
- R3: A lane whose exact value exceeds +32767 yields 0x7FFF. A lane whose exact value is below -32768 yields 0x8000. Any other value passes through unchanged, and each lane saturates independently of the other.
- R4: With `enc_sel`=0 (wide form), a word is recognised when bits [31:28] differ from 0xF, bits [27:20] equal 0x62 and bits [7:4] equal 0x5. Source A index is bits [19:16], destination is bits [15:12] and source B index is bits [3:0].
- R5: With `enc_sel`=1 (paired form), a word is recognised when bits [31:20] equal 0xFAE, bits [15:12] equal 0xF and bits [7:4] equal 0x1. Source A index is bits [19:16], destination is bits [11:8] and source B index is bits [3:0].
- R6: For a recognised word, `out_unpred` is 1 when any of the three indices equals 15.
- R7: In the wide form, bits [11:8] other than 0xF set `out_unpred`, while the result, destination and write enable are still produced normally.
- R8: `out_wen` is 1 only for a recognised word accepted while `cond_ok` is 1. An unpredictable word still writes when its condition passes.
- R9: An accepted word that the selected form does not recognise gives `out_illegal`=1 and `out_wen`=0, with `out_result` and `out_dst` equal to 0, for that one output cycle.
- R10: Outputs appear exactly one clock after `in_valid`, and `out_valid` copies `in_valid` delayed by one cycle. A cycle without input gives `out_valid`, `out_wen` and `out_illegal` all 0.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_wen`, `out_illegal`, `out_unpred`, `out_dst` and `out_result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and operands are present this cycle |
| enc_sel | input | 1 | 0 = wide form, 1 = paired form |
| cond_ok | input | 1 | Condition check passed |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Source operand A |
| opb | input | 32 | Source operand B |
| out_valid | output | 1 | Output cycle valid |
| out_dst | output | 4 | Destination register index |
| out_result | output | 32 | Packed saturated result |
| out_wen | output | 1 | Destination write enable |
| out_unpred | output | 1 | Unpredictable register use |
| out_illegal | output | 1 | Word not recognised |

## Verification
The two lanes can saturate in the same cycle, and in opposite directions. One example is the low sum clamping to 0x7FFF while the high difference clamps to 0x8000. The sweep crosses a set of corner halfwords (0x0000, ±1, 0x7FFF, 0x8000, 0x7FFE, 0x4000, 0xC000) over all four operand halves, which produces every mix of positive overflow, negative overflow and pass-through across the two lanes. Each lane of every vector is judged on its own against an integer model, so a carry or clamp that leaks from one lane into the other shows up as a miscompare in the lane that should have been untouched.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int IDX_W  = 4;
    localparam int LANES  = WORD_W / HALF_W;

    typedef enum logic {
        FORM_WIDE = 1'b0,
        FORM_PAIR = 1'b1
    } form_e;

    // Wide form match fields
    localparam logic [3:0]  WIDE_NEVER_COND = 4'hF;
    localparam logic [7:0]  WIDE_OPC_HI     = 8'h62;
    localparam logic [3:0]  WIDE_OPC_LO     = 4'h5;
    localparam logic [3:0]  WIDE_SBO        = 4'hF;
    // Paired form match fields
    localparam logic [11:0] PAIR_OPC_HI     = 12'hFAE;
    localparam logic [3:0]  PAIR_FIX_MID    = 4'hF;
    localparam logic [3:0]  PAIR_OPC_LO     = 4'h1;

    typedef struct packed {
        logic             legal;
        logic             unpred;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic              unpred;
        logic              illegal;
        logic [IDX_W-1:0]  dst;
        logic [WORD_W-1:0] result;
    } out_t;

    function automatic logic idx_reserved(input logic [IDX_W-1:0] idx);
        return idx == {IDX_W{1'b1}};
    endfunction

endpackage

// File: rtl/hsx_decode.sv
module hsx_decode
    import hsx_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    input  form_e             form,
    output dec_t              dec
);
    logic       wide_hit, pair_hit, sbo_bad, any_res;
    dec_t       wide_f, pair_f;

    always_comb begin
        wide_hit = (instr[31:28] != WIDE_NEVER_COND) &&
                   (instr[27:20] == WIDE_OPC_HI) &&
                   (instr[7:4]   == WIDE_OPC_LO);
        sbo_bad  = (instr[11:8] != WIDE_SBO);
        pair_hit = (instr[31:20] == PAIR_OPC_HI) &&
                   (instr[15:12] == PAIR_FIX_MID) &&
                   (instr[7:4]   == PAIR_OPC_LO);

        wide_f        = '0;
        wide_f.legal  = wide_hit;
        wide_f.src_a  = instr[19:16];
        wide_f.dst    = instr[15:12];
        wide_f.src_b  = instr[3:0];

        pair_f        = '0;
        pair_f.legal  = pair_hit;
        pair_f.src_a  = instr[19:16];
        pair_f.dst    = instr[11:8];
        pair_f.src_b  = instr[3:0];

        dec = (form == FORM_WIDE) ? wide_f : pair_f;
        any_res = idx_reserved(dec.dst) || idx_reserved(dec.src_a) ||
                  idx_reserved(dec.src_b);
        dec.unpred = dec.legal &&
                     (any_res || ((form == FORM_WIDE) && sbo_bad));
    end
endmodule

// File: rtl/hsx_lane.sv
module hsx_lane #(
    parameter int W   = 16,
    parameter bit SUB = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0] a_x, b_x, ext;

    assign a_x = {a[W-1], a};
    assign b_x = {b[W-1], b};

    generate
        if (SUB) begin : g_sub
            assign ext = a_x - b_x;
        end else begin : g_add
            assign ext = a_x + b_x;
        end
    endgenerate

    always_comb begin
        if (ext[W] != ext[W-1])
            y = ext[W] ? NEG_LIM : POS_LIM;
        else
            y = ext[W-1:0];
    end
endmodule

// File: rtl/hsx_unit.sv
module hsx_unit
    import hsx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              enc_sel,
    input  logic              cond_ok,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_dst,
    output logic [WORD_W-1:0] out_result,
    output logic              out_wen,
    output logic              out_unpred,
    output logic              out_illegal
);
    form_e             form;
    dec_t              dec;
    logic [WORD_W-1:0] lane_res;
    out_t              q, d;

    assign form = form_e'(enc_sel);

    hsx_decode u_dec (
        .instr (instr),
        .form  (form),
        .dec   (dec)
    );

    // Lane i pairs operand A half i with operand B half (LANES-1-i)
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            hsx_lane #(
                .W   (HALF_W),
                .SUB (i != 0)
            ) u_lane (
                .a (opa[i*HALF_W +: HALF_W]),
                .b (opb[(LANES-1-i)*HALF_W +: HALF_W]),
                .y (lane_res[i*HALF_W +: HALF_W])
            );
        end
    endgenerate

    always_comb begin
        d         = q;
        d.valid   = in_valid;
        d.wen     = in_valid && dec.legal && cond_ok;
        d.illegal = in_valid && !dec.legal;
        if (in_valid) begin
            d.unpred = dec.unpred;
            d.dst    = dec.legal ? dec.dst  : '0;
            d.result = dec.legal ? lane_res : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign out_valid   = q.valid;
    assign out_dst     = q.dst;
    assign out_result  = q.result;
    assign out_wen     = q.wen;
    assign out_unpred  = q.unpred;
    assign out_illegal = q.illegal;
endmodule

// File: rtl/hsx_unit_chk.sv
module hsx_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        cond_ok,
    input logic        out_valid,
    input logic [3:0]  out_dst,
    input logic [31:0] out_result,
    input logic        out_wen,
    input logic        out_unpred,
    input logic        out_illegal
);
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wen && !out_illegal));
    assert_wen_needs_cond_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cond_ok) |=> !out_wen);
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_wen && out_result == 32'h0 && out_dst == 4'h0));
    assert_wen_valid_R8: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_valid && !out_illegal));
    assert_dst15_unpred_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && out_dst == 4'hF) |-> out_unpred);
endmodule

bind hsx_unit hsx_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .cond_ok     (cond_ok),
    .out_valid   (out_valid),
    .out_dst     (out_dst),
    .out_result  (out_result),
    .out_wen     (out_wen),
    .out_unpred  (out_unpred),
    .out_illegal (out_illegal)
);

// File: tb/hsx_unit_tb.sv
`timescale 1ns/1ps
module hsx_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        enc_sel = 1'b0;
    logic        cond_ok = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid, out_wen, out_unpred, out_illegal;
    logic [3:0]  out_dst;
    logic [31:0] out_result;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    hsx_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .enc_sel(enc_sel),
        .cond_ok(cond_ok), .instr(instr), .opa(opa), .opb(opb),
        .out_valid(out_valid), .out_dst(out_dst), .out_result(out_result),
        .out_wen(out_wen), .out_unpred(out_unpred), .out_illegal(out_illegal)
    );

    function automatic logic [15:0] sat_ref(input int v);
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    function automatic logic [31:0] wide_word(input logic [3:0] d, a, b, sbo);
        return {4'hE, 8'h62, a, d, sbo, 4'h5, b};
    endfunction

    function automatic logic [31:0] pair_word(input logic [3:0] d, a, b);
        return {12'hFAE, a, 4'hF, d, 4'h1, b};
    endfunction

    task automatic apply(input logic [31:0] w, input logic sel, input logic cond,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic e_legal, input logic e_unpred,
                         input logic [3:0] e_dst, input string ctx);
        int        s_lo, s_hi;
        logic [15:0] e_lo, e_hi;
        bit        bad;
        bad  = 1'b0;
        s_lo = int'($signed(a[15:0]))  + int'($signed(b[31:16]));
        s_hi = int'($signed(a[31:16])) - int'($signed(b[15:0]));
        e_lo = e_legal ? sat_ref(s_lo) : 16'h0;
        e_hi = e_legal ? sat_ref(s_hi) : 16'h0;
        @(negedge clk);
        instr = w; enc_sel = sel; cond_ok = cond; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        vectors++;
        if (out_valid !== 1'b1) begin
            bad = 1'b1;
            $display("FAIL R10 %s valid act=%b exp=1", ctx, out_valid);
        end
        if (out_result[15:0] !== e_lo) begin
            bad = 1'b1;
            $display("FAIL R1 %s%s low lane act=%h exp=%h",
                     ctx, (s_lo > 32767 || s_lo < -32768) ? " R3" : "", out_result[15:0], e_lo);
        end
        if (out_result[31:16] !== e_hi) begin
            bad = 1'b1;
            $display("FAIL R2 %s%s high lane act=%h exp=%h",
                     ctx, (s_hi > 32767 || s_hi < -32768) ? " R3" : "", out_result[31:16], e_hi);
        end
        if (out_dst !== (e_legal ? e_dst : 4'h0)) begin
            bad = 1'b1;
            $display("FAIL %s %s dst act=%h exp=%h", sel ? "R5" : "R4", ctx, out_dst,
                     e_legal ? e_dst : 4'h0);
        end
        if (out_wen !== (e_legal && cond)) begin
            bad = 1'b1;
            $display("FAIL R8 %s wen act=%b exp=%b", ctx, out_wen, e_legal && cond);
        end
        if (out_illegal !== !e_legal) begin
            bad = 1'b1;
            $display("FAIL R9 %s illegal act=%b exp=%b", ctx, out_illegal, !e_legal);
        end
        if (out_unpred !== (e_legal && e_unpred)) begin
            bad = 1'b1;
            $display("FAIL R6 R7 %s unpred act=%b exp=%b", ctx, out_unpred, e_legal && e_unpred);
        end
        if (bad) errors++;
    endtask

    task automatic check_idle(input string ctx);
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_illegal !== 1'b0) begin
            errors++;
            $display("FAIL R10 %s idle v/w/i act=%b%b%b exp=000",
                     ctx, out_valid, out_wen, out_illegal);
        end
    endtask

    logic [15:0] corners [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                 16'h8000, 16'h7FFE, 16'h4000, 16'hC000};

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        vectors++;
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_illegal !== 1'b0 ||
            out_unpred !== 1'b0 || out_dst !== 4'h0 || out_result !== 32'h0) begin
            errors++;
            $display("FAIL R11 reset state act=%b%b%b%b %h %h exp=0000 0 0",
                     out_valid, out_wen, out_illegal, out_unpred, out_dst, out_result);
        end
        rst = 1'b0;

        // R1 R2 R3 sweep over corner halfwords, alternating both forms (R4 R5)
        for (int i = 0; i < 4096; i++) begin
            logic [31:0] a, b;
            a = {corners[(i>>9)&7], corners[(i>>6)&7]};
            b = {corners[(i>>3)&7], corners[i&7]};
            if (i[0])
                apply(pair_word(4'h6, 4'h1, 4'h2), 1'b1, 1'b1, a, b, 1'b1, 1'b0, 4'h6, "sweep pair R5");
            else
                apply(wide_word(4'h3, 4'h4, 4'h5, 4'hF), 1'b0, 1'b1, a, b, 1'b1, 1'b0, 4'h3, "sweep wide R4");
        end
        check_idle("after sweep");

        // R8: condition fails, no write
        apply(wide_word(4'h2, 4'h0, 4'h1, 4'hF), 1'b0, 1'b0, 32'h7FFF0001, 32'h00018000,
              1'b1, 1'b0, 4'h2, "cond fail wide R8");
        apply(pair_word(4'h2, 4'h0, 4'h1), 1'b1, 1'b0, 32'h12345678, 32'h11112222,
              1'b1, 1'b0, 4'h2, "cond fail pair R8");

        // R6: reserved index in each position, both forms; still writes (R8)
        for (int p = 0; p < 3; p++) begin
            logic [3:0] d, s1, s2;
            d  = (p == 0) ? 4'hF : 4'h1;
            s1 = (p == 1) ? 4'hF : 4'h2;
            s2 = (p == 2) ? 4'hF : 4'h3;
            apply(wide_word(d, s1, s2, 4'hF), 1'b0, 1'b1, 32'h80007FFF, 32'h7FFF8000,
                  1'b1, 1'b1, d, "index 15 wide R6");
            apply(pair_word(d, s1, s2), 1'b1, 1'b1, 32'h00010002, 32'h00030004,
                  1'b1, 1'b1, d, "index 15 pair R6");
        end

        // R7: should-be-one bits not all ones
        apply(wide_word(4'h7, 4'h8, 4'h9, 4'h0), 1'b0, 1'b1, 32'h7FFF7FFF, 32'h7FFF8000,
              1'b1, 1'b1, 4'h7, "sbo clear R7");
        apply(wide_word(4'h7, 4'h8, 4'h9, 4'hE), 1'b0, 1'b1, 32'h00050006, 32'h00070008,
              1'b1, 1'b1, 4'h7, "sbo partial R7");

        // R9: unrecognised words
        apply({4'hF, 8'h62, 4'h1, 4'h2, 4'hF, 4'h5, 4'h3}, 1'b0, 1'b1, 32'h1, 32'h2,
              1'b0, 1'b0, 4'h0, "never cond R9");
        apply({4'hE, 8'h63, 4'h1, 4'h2, 4'hF, 4'h5, 4'h3}, 1'b0, 1'b1, 32'h1, 32'h2,
              1'b0, 1'b0, 4'h0, "bad opc wide R9");
        apply(wide_word(4'h1, 4'h2, 4'h3, 4'hF), 1'b1, 1'b1, 32'h1, 32'h2,
              1'b0, 1'b0, 4'h0, "wide word in pair mode R9");
        apply({12'hFAE, 4'h1, 4'hE, 4'h2, 4'h1, 4'h3}, 1'b1, 1'b1, 32'h1, 32'h2,
              1'b0, 1'b0, 4'h0, "pair mid bad R9");
        apply({12'hFAE, 4'h1, 4'hF, 4'h2, 4'h0, 4'h3}, 1'b1, 1'b1, 32'h1, 32'h2,
              1'b0, 1'b0, 4'h0, "pair low opc bad R9");
        check_idle("illegal is one cycle R9");

        // R11: reset during activity
        @(negedge clk);
        instr = wide_word(4'h1, 4'h2, 4'h3, 4'hF); enc_sel = 1'b0; cond_ok = 1'b1;
        opa = 32'h00010001; opb = 32'h00010001; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        vectors++;
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_result !== 32'h0 || out_dst !== 4'h0) begin
            errors++;
            $display("FAIL R11 mid-run reset act=%b%b %h %h exp=00 0 0",
                     out_valid, out_wen, out_dst, out_result);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule